// File: doc/BRIEF.md
# Serial DAC Code Loader

This block is the digital front end of an 18-bit voltage-output DAC. A host writes 24-bit frames over three wires: an active-low frame-select, a serial clock and a data line. All three are brought into the system clock domain, and falling edges of the serial clock shift data in. When a complete frame has been received, the 18-bit code is copied into a holding register that drives the converter.

A frame only starts when frame-select falls. The code register loads on the 24th serial-clock fall and does not wait for frame-select to rise. If frame-select rises before the 24th fall, the frame is discarded and the held code stays as it was. After a completed frame, any further clock edges are ignored. Frame-select must go high and then low again before another write is accepted. A build-time parameter sets the power-up code to either zero-scale or midscale.

The system clock must run at least four times faster than the serial clock. Each serial-clock level must last at least two system-clock periods.

Top module: `sdac_input_if`

## Requirements
- R1: After synchronous reset the code output equals the power-up value. With `INIT = INIT_ZERO` the value is 0. With `INIT = INIT_MID` only bit 17 is set (0x20000). The value holds until the first complete frame.
- R2: A frame starts only on a falling edge of `sync_n_i`. Serial-clock edges while `sync_n_i` is high neither shift data nor change the code.
- R3: `din_i` is sampled on each `sclk_i` falling edge, frame bit 23 first. Frame bits 19..2 become the code, with frame bit 19 as the code MSB.
- R4: The code output takes its new value on the third system-clock rising edge after the 24th `sclk_i` fall. This happens while `sync_n_i` is still low, without waiting for it to rise.
- R5: If `sync_n_i` rises after fewer than 24 falls, the partial frame is discarded and the code is unchanged. The next frame is received from its first bit.
- R6: Serial-clock falls after the 24th, while `sync_n_i` stays low, neither shift data nor cause a second load. A new write needs `sync_n_i` to go high and then low.
- R7: `update_o` is high for exactly one system-clock cycle, in the cycle in which the new code first appears. Frame bits 23..20 and 1..0 have no effect on the code, and a frame with them set still loads and pulses.
- R8: A synchronous reset during a partly received frame restores the power-up code and discards the partial bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n_i | input | 1 | Active-low frame select (asynchronous) |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge (asynchronous) |
| din_i | input | 1 | Serial data, frame bit 23 first (asynchronous) |
| dac_code_o | output | 18 | Held DAC code |
| update_o | output | 1 | One-cycle pulse when a new code is loaded |

## Verification
The path from any serial input to the result has three clocks: two synchronizer flops, and then the register that holds the code and the pulse. The code and `update_o` therefore change on the third system-clock rising edge after the 24th serial-clock fall. The bench drives its inputs on falling edges of the system clock and samples on falling edges. In the latency test it reads the outputs exactly two and three cycles after the final fall, so it sees the old value and then the new value with the pulse. The pulse is gone one cycle later. Every other check waits four cycles or more after the last relevant edge, which is beyond that three-cycle latency.

// File: rtl/sdac_pkg.sv
// Shared types for the serial DAC code loader.
package sdac_pkg;
    // Selects the value the code register takes at reset.
    typedef enum logic {
        INIT_ZERO = 1'b0,
        INIT_MID  = 1'b1
    } init_sel_e;
endpackage

// File: rtl/sdac_sync2.sv
// Two-flop synchronizer for a bundle of independent asynchronous lines.
// Assumes each line is quasi-static relative to clk; no cross-bit coherence.
module sdac_sync2 #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/sdac_frame_rx.sv
// Frame receiver: detects frame-select and serial-clock edges on
// synchronized lines, shifts data in and flags the final bit.
// Assumes CODE_LSB >= 1 and CODE_LSB + CODE_W <= FRAME_W.
// frame_done is combinational and valid in the cycle of the last falling edge;
// code_next is valid in that same cycle.
module sdac_frame_rx #(
    parameter int FRAME_W  = 24,
    parameter int CODE_W   = 18,
    parameter int CODE_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    output logic              frame_done,
    output logic [CODE_W-1:0] code_next
);
    localparam int             CW     = $clog2(FRAME_W);
    localparam int             KEEP_W = CODE_LSB + CODE_W - 1;
    localparam logic [CW-1:0]  LAST   = CW'(FRAME_W - 1);

    logic              sync_n_d, sclk_d;
    logic              armed;
    logic [CW-1:0]     cnt;
    logic [KEEP_W-1:0] shreg;
    logic              sclk_fall, sync_fall, shift_en, last_bit;

    // Edge detection on the synchronized lines.
    always_comb begin
        sclk_fall = sclk_d & ~sclk_s;
        sync_fall = sync_n_d & ~sync_n_s;
        shift_en  = armed & sclk_fall & ~sync_n_s;
        last_bit  = (cnt == LAST);
    end

    assign frame_done = shift_en & last_bit;
    // Before the final shift, shreg[i] holds frame bit i+1.
    assign code_next  = shreg[KEEP_W-1 -: CODE_W];

    // Frame state: arming, bit counting, shifting, aborting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_n_d <= 1'b0;
            sclk_d   <= 1'b0;
            armed    <= 1'b0;
            cnt      <= '0;
            shreg    <= '0;
        end else begin
            sync_n_d <= sync_n_s;
            sclk_d   <= sclk_s;
            if (sync_n_s) begin
                armed <= 1'b0;
                cnt   <= '0;
                shreg <= '0;
            end else if (sync_fall) begin
                armed <= 1'b1;
                cnt   <= '0;
                shreg <= '0;
            end else if (shift_en) begin
                shreg <= {shreg[KEEP_W-2:0], din_s};
                if (last_bit) begin
                    armed <= 1'b0;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R5: a high frame select leaves the receiver idle and empty.
    a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n_s |=> (cnt == '0 && !armed));

    // R2: the receiver arms only one cycle after a frame-select fall.
    a_r2_arm_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(sync_n_d && !sync_n_s));

    // R6: after the final bit the receiver stays disarmed.
    a_r6_disarm_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !armed);
endmodule

// File: rtl/sdac_code_hold.sv
// DAC holding register: loads the extracted code on a frame strobe and
// emits a one-cycle update pulse aligned with the new value.
module sdac_code_hold
    import sdac_pkg::*;
#(
    parameter int        CODE_W = 18,
    parameter init_sel_e INIT   = INIT_ZERO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q,
    output logic              update_q
);
    localparam logic [CODE_W-1:0] INIT_VAL =
        (INIT == INIT_MID) ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

    // Holding register and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= INIT_VAL;
            update_q <= 1'b0;
        end else begin
            update_q <= load;
            if (load) begin
                code_q <= code_in;
            end
        end
    end

    // R1: reset leaves the configured power-up code.
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> (code_q == INIT_VAL && !update_q));

    // R4: without a load the held code does not move.
    a_r4_hold_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code_q));
endmodule

// File: rtl/sdac_input_if.sv
// Top of the serial DAC code loader: synchronizes the three serial lines,
// receives 24-bit frames and holds the 18-bit code.
// Assumes clk runs at least 4x the serial clock rate.
module sdac_input_if
    import sdac_pkg::*;
#(
    parameter int        FRAME_W  = 24,
    parameter int        CODE_W   = 18,
    parameter int        CODE_LSB = 2,
    parameter init_sel_e INIT     = INIT_ZERO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n_i,
    input  logic              sclk_i,
    input  logic              din_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              update_o
);
    logic [2:0]        lines_s;
    logic              frame_done;
    logic [CODE_W-1:0] code_next;

    sdac_sync2 #(.W(3), .RST_VAL(3'b000)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sync_n_i, sclk_i, din_i}),
        .q     (lines_s)
    );

    sdac_frame_rx #(
        .FRAME_W  (FRAME_W),
        .CODE_W   (CODE_W),
        .CODE_LSB (CODE_LSB)
    ) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_n_s   (lines_s[2]),
        .sclk_s     (lines_s[1]),
        .din_s      (lines_s[0]),
        .frame_done (frame_done),
        .code_next  (code_next)
    );

    sdac_code_hold #(.CODE_W(CODE_W), .INIT(INIT)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_done),
        .code_in  (code_next),
        .code_q   (dac_code_o),
        .update_q (update_o)
    );

    // R7: the update strobe never lasts two cycles.
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);
endmodule

// File: tb/sdac_input_if_tb_top.sv
// Self-checking bench for the serial DAC code loader.
module sdac_input_if_tb_top;
    import sdac_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [17:0] code, code_mid;
    logic        upd, upd_mid;

    int n_tests = 0;
    int n_fail  = 0;
    int upd_cnt = 0;
    int dbl_cnt = 0;
    logic upd_prev = 1'b0;

    always #10 clk = ~clk;

    sdac_input_if dut_i (
        .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk),
        .din_i(din), .dac_code_o(code), .update_o(upd)
    );

    sdac_input_if #(.INIT(INIT_MID)) dut_mid_i (
        .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk),
        .din_i(din), .dac_code_o(code_mid), .update_o(upd_mid)
    );

    // Pulse monitor: counts strobes and strobes wider than one cycle.
    always @(negedge clk) begin
        if (upd) upd_cnt++;
        if (upd && upd_prev) dbl_cnt++;
        upd_prev = upd;
    end

    // Stimulus frame and expected code.
    localparam logic [41:0] VECS [7] = '{
        {24'h0FFFFC, 18'h3FFFF},
        {24'h000000, 18'h00000},
        {24'hF00003, 18'h00000},
        {24'h080000, 18'h20000},
        {24'h000004, 18'h00001},
        {24'h3AAAA8, 18'h2AAAA},
        {24'hC55557, 18'h15555}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bits(input logic [23:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            din  = w[23-i];
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
        end
    endtask

    task automatic send(input logic [23:0] w, input int n, input bit release_sync);
        sync_n = 1'b1;
        wait_clk(4);
        sync_n = 1'b0;
        wait_clk(4);
        pulse_bits(w, n);
        if (release_sync) begin
            sync_n = 1'b1;
            wait_clk(4);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base;
        wait_clk(4);
        chk("R1 reset code zero", 32'(code), 32'h0);
        chk("R1 reset code mid", 32'(code_mid), 32'h20000);
        chk("R1 no strobe in reset", 32'(upd), 32'h0);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1 code held after reset", 32'(code), 32'h0);

        // Table walk: R3 bit mapping, R7 ignored bits and one strobe per frame.
        foreach (VECS[k]) begin
            base = upd_cnt;
            send(VECS[k][41:18], 24, 1'b1);
            chk($sformatf("R3 frame %h code", VECS[k][41:18]), 32'(code), 32'(VECS[k][17:0]));
            chk($sformatf("R7 frame %h one strobe", VECS[k][41:18]), 32'(upd_cnt - base), 32'd1);
        end
        chk("R1 mid instance follows frame", 32'(code_mid), 32'h15555);

        // R4: exact latency, and the load happens with frame select still low.
        send(24'h000008, 23, 1'b0);
        din  = 1'b0;
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
        wait_clk(2);
        chk("R4 old code 2 cycles after last fall", 32'(code), 32'h15555);
        wait_clk(1);
        chk("R4 new code 3 cycles after last fall", 32'(code), 32'h2);
        chk("R7 strobe with new code", 32'(upd), 32'h1);
        wait_clk(1);
        chk("R7 strobe one cycle only", 32'(upd), 32'h0);
        wait_clk(8);
        chk("R4 loaded before frame select rises", 32'(code), 32'h2);
        sync_n = 1'b1;
        wait_clk(4);
        chk("R4 no change on frame select rise", 32'(code), 32'h2);

        // R6: extra edges after the 24th are ignored until re-selected.
        send(24'h080000, 24, 1'b0);
        base = upd_cnt;
        pulse_bits(24'h0FFFFC, 24);
        chk("R6 extra edges keep code", 32'(code), 32'h20000);
        chk("R6 extra edges no strobe", 32'(upd_cnt - base), 32'd0);
        send(24'h0FFFFC, 24, 1'b1);
        chk("R6 new frame after reselect", 32'(code), 32'h3FFFF);

        // R5: aborted frame discarded, next frame starts clean.
        base = upd_cnt;
        send(24'h000004, 23, 1'b1);
        chk("R5 aborted frame keeps code", 32'(code), 32'h3FFFF);
        chk("R5 aborted frame no strobe", 32'(upd_cnt - base), 32'd0);
        send(24'h000004, 24, 1'b1);
        chk("R5 frame after abort", 32'(code), 32'h1);

        // R2: clock edges with frame select high are ignored.
        base = upd_cnt;
        sync_n = 1'b1;
        din    = 1'b1;
        for (int i = 0; i < 30; i++) begin
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
        end
        chk("R2 edges while deselected keep code", 32'(code), 32'h1);
        chk("R2 edges while deselected no strobe", 32'(upd_cnt - base), 32'd0);

        // R8: reset during a partial frame.
        send(24'h0FFFFC, 12, 1'b0);
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R8 reset mid-frame restores zero", 32'(code), 32'h0);
        chk("R8 reset mid-frame restores mid", 32'(code_mid), 32'h20000);
        send(24'h000004, 24, 1'b1);
        chk("R8 clean frame after reset", 32'(code), 32'h1);

        chk("R7 no double-width strobe", 32'(dbl_cnt), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule